// File: doc/BRIEF.md
# Power-Up Select Latch Sequencer

This block decides when a clock generator may start driving its outputs after power is applied. It watches a digital flag that reports that the analog supply has reached its working level. It also watches an active-low qualifier from the termination supply. When the qualifier goes low, the block waits a fixed time, captures the frequency-select and multiplier-select pins, and only then raises an output enable toward the clock gating.

The top frequency-select bit comes from a three-level pin that has already been decoded into a two-bit level code. Only the high level is stored as a one. The two asynchronous status inputs pass through a resynchronizer of configurable depth. The delay is counted in reference-clock cycles: its length is set in microseconds and converted with the reference clock rate. Once the block is running, its captured values stay fixed until the supply flag drops. A drop sends the block back to its idle phase.

Top module: `pwrup_sel_seq`

## Requirements
- R1: After reset, `phase` is 0 (off), `out_en` is 0, and `sel_latched` and `mult_latched` are 0.
- R2: While the synchronized supply flag is low, `phase` stays 0 whatever the qualifier does. After `supply_ok` rises, `phase` becomes 1 (waiting for qualifier) on the (SYNC_STAGES+1)-th rising clock edge.
- R3: In phase 1 with the supply good, a synchronized qualifier that is high keeps phase 1, and a synchronized qualifier that is low moves to phase 2 (delay and sample) on the next edge.
- R4: Phase 2 lasts exactly DELAY_CYCLES clock cycles, where DELAY_CYCLES = REF_CLK_KHZ*DELAY_US/1000. DELAY_US must lie between 200 and 300.
- R5: On the edge that ends the delay, `sel_lo` and `mult_pin` are captured into the low bits of `sel_latched` and into `mult_latched`, and `phase` becomes 3 (run).
- R6: The top bit of `sel_latched` is 1 only when `sel_top_lvl` is 2'b10 (high) at capture. Codes 2'b00 (low), 2'b01 (mid) and 2'b11 all store 0.
- R7: `out_en` is 1 exactly in the cycles where `phase` is 3.
- R8: In phase 3, changes on `vtt_pg_n`, `sel_top_lvl`, `sel_lo` and `mult_pin` change neither the captured values nor `out_en`.
- R9: If the synchronized qualifier goes high again during phase 2, the block returns to phase 1, and the next low qualifier restarts the full delay.
- R10: A synchronized supply flag that is low while in phase 1, 2 or 3 returns the block to phase 0 on the next edge and drops `out_en`.
- R11: `sel_latched` and `mult_latched` are 0 in every phase other than 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencing logic |
| supply_ok | input | 1 | Analog supply has reached its valid level (asynchronous) |
| vtt_pg_n | input | 1 | Active-low power-good qualifier (asynchronous) |
| sel_top_lvl | input | 2 | Decoded level of the top select pin: 00 low, 01 mid, 10 high |
| sel_lo | input | SEL_LO_W | Lower frequency-select pins |
| mult_pin | input | 1 | Output-current multiplier select pin |
| out_en | output | 1 | Enable to the clock output gating |
| phase | output | 2 | Sequencer phase: 0 off, 1 wait qualifier, 2 delay/sample, 3 run |
| sel_latched | output | SEL_LO_W+1 | Captured frequency select, top bit from the level code |
| mult_latched | output | 1 | Captured multiplier select |

## Verification
The hardest situation to reach is an aborted delay. The qualifier has to rise again partway through the sample phase and then fall once more, and the restarted count must run its full length. The bench reaches it by holding the qualifier low for fewer cycles than the delay before releasing it. It also drops the supply flag while the count is running, and it wiggles every select pin and the qualifier once the block is in the run phase. A behavioural model that includes the resynchronizer latency is compared against the outputs on every cycle, so any off-by-one in the count length or in the capture edge shows up immediately.

// File: rtl/pwrup_seq_pkg.sv
package pwrup_seq_pkg;

   typedef enum logic [1:0] {
      PH_OFF    = 2'd0,
      PH_WAIT   = 2'd1,
      PH_SAMPLE = 2'd2,
      PH_RUN    = 2'd3
   } phase_e;

   localparam logic [1:0] LVL_LOW  = 2'b00;
   localparam logic [1:0] LVL_MID  = 2'b01;
   localparam logic [1:0] LVL_HIGH = 2'b10;

   function automatic int unsigned delay_cycles(input int unsigned clk_khz,
                                                input int unsigned dly_us);
      return (clk_khz * dly_us) / 1000;
   endfunction

endpackage

// File: rtl/pwrup_sync.sv
module pwrup_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else if (STAGES == 1) chain[0] <= d;
            else chain <= {chain[STAGES-2:0], d};
         end
         assign q = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/pwrup_delay_cnt.sv
module pwrup_delay_cnt #(
   parameter int LENGTH = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic done
);

   localparam int CNT_W = $clog2(LENGTH + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LENGTH - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (clr)            cnt <= '0;
      else if (en && !done)    cnt <= cnt + 1'b1;
   end

   assign done = (cnt == LAST);

   // R4: the count never runs past its terminal value
   assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (cnt <= LAST));

endmodule

// File: rtl/pwrup_sel_capture.sv
module pwrup_sel_capture
   import pwrup_seq_pkg::*;
#(
   parameter int LO_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cap,
   input  logic            clr,
   input  logic [1:0]      top_lvl,
   input  logic [LO_W-1:0] lo,
   input  logic            mult,
   output logic [LO_W:0]   sel_q,
   output logic            mult_q
);

   logic top_bit;
   assign top_bit = (top_lvl == LVL_HIGH);

   generate
      for (genvar i = 0; i < LO_W; i++) begin : g_lo
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   sel_q[i] <= 1'b0;
            else if (clr) sel_q[i] <= 1'b0;
            else if (cap) sel_q[i] <= lo[i];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q[LO_W] <= 1'b0;
         mult_q      <= 1'b0;
      end else if (clr) begin
         sel_q[LO_W] <= 1'b0;
         mult_q      <= 1'b0;
      end else if (cap) begin
         sel_q[LO_W] <= top_bit;
         mult_q      <= mult;
      end
   end

   // R6: a non-high level on the top pin is stored as zero
   assert_mid_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cap && !clr && top_lvl != LVL_HIGH) |=> !sel_q[LO_W]);

endmodule

// File: rtl/pwrup_seq_fsm.sv
module pwrup_seq_fsm
   import pwrup_seq_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   sup_s,
   input  logic   vtt_s,
   input  logic   dly_done,
   output phase_e phase,
   output logic   cnt_clr,
   output logic   cnt_en,
   output logic   cap,
   output logic   lat_clr
);

   phase_e nxt;

   always_comb begin
      nxt = phase;
      unique case (phase)
         PH_OFF:    if (sup_s) nxt = PH_WAIT;
         PH_WAIT:   if (!sup_s) nxt = PH_OFF;
                    else if (!vtt_s) nxt = PH_SAMPLE;
         PH_SAMPLE: if (!sup_s) nxt = PH_OFF;
                    else if (vtt_s) nxt = PH_WAIT;
                    else if (dly_done) nxt = PH_RUN;
         PH_RUN:    if (!sup_s) nxt = PH_OFF;
         default:   nxt = PH_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= PH_OFF;
      else        phase <= nxt;
   end

   assign cnt_en  = (phase == PH_SAMPLE);
   assign cnt_clr = (phase != PH_SAMPLE);
   assign cap     = (phase == PH_SAMPLE) && (nxt == PH_RUN);
   assign lat_clr = (phase != PH_OFF) && (nxt == PH_OFF);

   // R2: no exit from off without a good supply
   assert_off_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_OFF && !sup_s) |=> (phase == PH_OFF));

   // R3: a high qualifier keeps the wait phase
   assert_wait_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WAIT && sup_s && vtt_s) |=> (phase == PH_WAIT));

   // R9: qualifier release during the delay returns to wait
   assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SAMPLE && sup_s && vtt_s) |=> (phase == PH_WAIT));

   // R10: supply loss always returns to off
   assert_drop_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_OFF && !sup_s) |=> (phase == PH_OFF));

endmodule

// File: rtl/pwrup_sel_seq.sv
module pwrup_sel_seq
   import pwrup_seq_pkg::*;
#(
   parameter int SEL_LO_W    = 2,
   parameter int SYNC_STAGES = 2,
   parameter int REF_CLK_KHZ = 14318,
   parameter int DELAY_US    = 250
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                supply_ok,
   input  logic                vtt_pg_n,
   input  logic [1:0]          sel_top_lvl,
   input  logic [SEL_LO_W-1:0] sel_lo,
   input  logic                mult_pin,
   output logic                out_en,
   output logic [1:0]          phase,
   output logic [SEL_LO_W:0]   sel_latched,
   output logic                mult_latched
);

   localparam int DELAY_CYCLES = delay_cycles(REF_CLK_KHZ, DELAY_US);

   generate
      if (DELAY_US < 200 || DELAY_US > 300) begin : g_bad_delay
         $error("pwrup_sel_seq: DELAY_US must lie in 200..300");
      end
      if (DELAY_CYCLES < 1) begin : g_bad_cycles
         $error("pwrup_sel_seq: delay rounds to zero cycles");
      end
      if (SEL_LO_W < 1) begin : g_bad_width
         $error("pwrup_sel_seq: SEL_LO_W must be at least 1");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("pwrup_sel_seq: SYNC_STAGES must not be negative");
      end
   endgenerate

   logic   sup_s, vtt_s, dly_done, cnt_clr, cnt_en, cap, lat_clr;
   phase_e ph;

   pwrup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sup (
      .clk(clk), .rst_n(rst_n), .d(supply_ok), .q(sup_s));

   pwrup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_vtt (
      .clk(clk), .rst_n(rst_n), .d(vtt_pg_n), .q(vtt_s));

   pwrup_seq_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .sup_s(sup_s), .vtt_s(vtt_s),
      .dly_done(dly_done), .phase(ph), .cnt_clr(cnt_clr),
      .cnt_en(cnt_en), .cap(cap), .lat_clr(lat_clr));

   pwrup_delay_cnt #(.LENGTH(DELAY_CYCLES)) u_dly (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cnt_en), .done(dly_done));

   pwrup_sel_capture #(.LO_W(SEL_LO_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .cap(cap), .clr(lat_clr),
      .top_lvl(sel_top_lvl), .lo(sel_lo), .mult(mult_pin),
      .sel_q(sel_latched), .mult_q(mult_latched));

   assign phase  = ph;
   assign out_en = (ph == PH_RUN);

   // R5: the delay ending with the qualifier still low lands in run
   assert_enter_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_SAMPLE && sup_s && !vtt_s && dly_done) |=> (ph == PH_RUN));

   // R8: captured values are frozen in run while the supply is good
   assert_run_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_RUN && sup_s) |=> (ph == PH_RUN && $stable(sel_latched) && $stable(mult_latched)));

   // R11: captured values read zero outside run
   assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ph != PH_RUN) |-> (sel_latched == '0 && !mult_latched));

endmodule

// File: tb/pwrup_sel_seq_tb.sv
module pwrup_sel_seq_tb;

   localparam int LO_W = 2;
   localparam int SYNC = 2;
   localparam int KHZ  = 40;
   localparam int DUS  = 250;
   localparam int DLY  = (KHZ * DUS) / 1000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic supply_ok = 1'b0;
   logic vtt_pg_n = 1'b1;
   logic [1:0] sel_top_lvl = 2'b00;
   logic [LO_W-1:0] sel_lo = '0;
   logic mult_pin = 1'b0;
   logic out_en;
   logic [1:0] phase;
   logic [LO_W:0] sel_latched;
   logic mult_latched;

   int checks = 0;
   int fails  = 0;
   bit done_flag = 1'b0;

   always #2.5 clk = ~clk;

   pwrup_sel_seq #(.SEL_LO_W(LO_W), .SYNC_STAGES(SYNC),
                   .REF_CLK_KHZ(KHZ), .DELAY_US(DUS)) u_dut (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .vtt_pg_n(vtt_pg_n),
      .sel_top_lvl(sel_top_lvl), .sel_lo(sel_lo), .mult_pin(mult_pin),
      .out_en(out_en), .phase(phase), .sel_latched(sel_latched),
      .mult_latched(mult_latched));

   // behavioural reference model
   int m_phase = 0;
   int m_cnt = 0;
   int m_sel = 0;
   int m_mult = 0;
   bit m_sup [SYNC];
   bit m_vtt [SYNC];

   task automatic model_reset();
      m_phase = 0; m_cnt = 0; m_sel = 0; m_mult = 0;
      for (int i = 0; i < SYNC; i++) begin
         m_sup[i] = 1'b0;
         m_vtt[i] = 1'b1;
      end
   endtask

   initial model_reset();

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else begin
         bit s, v;
         s = m_sup[SYNC-1];
         v = m_vtt[SYNC-1];
         case (m_phase)
            0: if (s) m_phase = 1;
            1: if (!s) m_phase = 0;
               else if (!v) begin m_phase = 2; m_cnt = 0; end
            2: if (!s) m_phase = 0;
               else if (v) m_phase = 1;
               else if (m_cnt == DLY - 1) begin
                  m_phase = 3;
                  m_sel = ((sel_top_lvl == 2'b10) ? 4 : 0) + int'(sel_lo);
                  m_mult = int'(mult_pin);
               end else m_cnt++;
            default: if (!s) m_phase = 0;
         endcase
         if (m_phase == 0) begin m_sel = 0; m_mult = 0; end
         for (int i = SYNC - 1; i > 0; i--) begin
            m_sup[i] = m_sup[i-1];
            m_vtt[i] = m_vtt[i-1];
         end
         m_sup[0] = supply_ok;
         m_vtt[0] = vtt_pg_n;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done_flag) begin
         check("R3 phase vs model", int'(phase), m_phase);
         check("R7 out_en vs model", int'(out_en), (m_phase == 3) ? 1 : 0);
         check("R5 sel_latched vs model", int'(sel_latched), m_sel);
         check("R5 mult_latched vs model", int'(mult_latched), m_mult);
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_phase(input int p);
      int guard = 0;
      while (int'(phase) != p && guard < 200) begin
         @(negedge clk);
         guard++;
      end
   endtask

   initial begin
      int n;
      cyc(3);
      // R1: reset state
      check("R1 phase", int'(phase), 0);
      check("R1 out_en", int'(out_en), 0);
      check("R1 latched", int'(sel_latched) + int'(mult_latched), 0);
      rst_n = 1'b1;
      cyc(2);

      // R2: qualifier activity with no supply leaves off
      vtt_pg_n = 1'b0; cyc(6); vtt_pg_n = 1'b1; cyc(6);
      check("R2 stays off", int'(phase), 0);

      // R2: exit latency of SYNC+1 edges
      supply_ok = 1'b1;
      cyc(SYNC);
      check("R2 still off before sync", int'(phase), 0);
      cyc(1);
      check("R2 enters wait", int'(phase), 1);
      cyc(5);
      check("R3 high qualifier holds wait", int'(phase), 1);

      // R9: abort the delay partway
      sel_top_lvl = 2'b01; sel_lo = 2'b01; mult_pin = 1'b1;
      vtt_pg_n = 1'b0;
      cyc(SYNC + 1);
      check("R3 enters sample", int'(phase), 2);
      cyc(3);
      vtt_pg_n = 1'b1;
      cyc(SYNC + 1);
      check("R9 back to wait", int'(phase), 1);
      check("R11 zero in wait", int'(sel_latched), 0);

      // R4: full delay length after restart; R6 mid stored as 0
      vtt_pg_n = 1'b0;
      wait_phase(2);
      n = 0;
      while (int'(phase) == 2 && n < 100) begin @(negedge clk); n++; end
      check("R4 delay length", n, DLY);
      check("R5 run entered", int'(phase), 3);
      check("R6 mid stored as zero", int'(sel_latched), 3'b001);
      check("R5 mult captured", int'(mult_latched), 1);
      check("R7 out_en in run", int'(out_en), 1);

      // R8: wiggle everything in run
      sel_top_lvl = 2'b10; sel_lo = 2'b10; mult_pin = 1'b0;
      vtt_pg_n = 1'b1; cyc(5); vtt_pg_n = 1'b0; cyc(3); vtt_pg_n = 1'b1; cyc(6);
      check("R8 sel held", int'(sel_latched), 3'b001);
      check("R8 mult held", int'(mult_latched), 1);
      check("R8 still running", int'(out_en), 1);

      // R10, R11: supply drop from run
      supply_ok = 1'b0;
      cyc(SYNC + 1);
      check("R10 off after drop", int'(phase), 0);
      check("R10 out_en low", int'(out_en), 0);
      check("R11 cleared", int'(sel_latched) + int'(mult_latched), 0);

      // R6: high level stored as 1
      supply_ok = 1'b1; cyc(SYNC + 3);
      sel_top_lvl = 2'b10; sel_lo = 2'b10; mult_pin = 1'b0;
      vtt_pg_n = 1'b0;
      wait_phase(3);
      check("R6 high stored as one", int'(sel_latched), 3'b110);
      check("R5 mult zero captured", int'(mult_latched), 0);

      // R10: drop during sample phase
      supply_ok = 1'b0; cyc(SYNC + 2);
      supply_ok = 1'b1; vtt_pg_n = 1'b1; cyc(SYNC + 3);
      sel_top_lvl = 2'b11; sel_lo = 2'b11; mult_pin = 1'b1;
      vtt_pg_n = 1'b0;
      wait_phase(2);
      cyc(4);
      supply_ok = 1'b0;
      cyc(SYNC + 1);
      check("R10 off from sample", int'(phase), 0);

      // R6: code 11 and low code both store 0
      supply_ok = 1'b1;
      wait_phase(3);
      check("R6 code 11 stored as zero", int'(sel_latched), 3'b011);
      supply_ok = 1'b0; cyc(SYNC + 2);
      sel_top_lvl = 2'b00; sel_lo = 2'b00; mult_pin = 1'b0;
      supply_ok = 1'b1;
      wait_phase(3);
      check("R6 low stored as zero", int'(sel_latched), 0);
      check("R7 run with zero selects", int'(out_en), 1);
      cyc(3);

      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         done_flag = 1'b1;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule